// File: doc/BRIEF.md
# Dual Stack Pointer Unit with Return Address Shortcut

This unit manages two stack pointers. One serves normal mode and the other serves exception mode. The exception-mode input selects the active pointer. The other pointer can be read at all times and can be written through a dedicated operation. For 8-byte stack frames the unit generates the memory request, the direction and the address, and it updates the pointer it targets. The stack grows upward, and each frame holds an even register in its lower word and an odd register in its upper word. The two normal-stack operations always use the normal pointer, so exception-level code can reach the normal stack without a mode switch.

A subroutine call pushes a frame on the active stack. It also copies the return PC into a one-entry return register and tags that register valid. On return, the pointer drops by 8 in every case. When the tag is valid, the PC comes out in the same cycle and no memory access takes place. When the tag is clear, the unit reads the stacked PC at the old pointer minus 8. It holds its stall output until the read data arrives, and it ignores new operations until then. An explicit write to the active pointer clears the tag, and so does any change of mode.

Top module: `dual_sp_ctrl`

## Requirements
- R1: After reset the normal pointer holds 0x1000 and the exception pointer holds 0x8000. The return tag is clear and stall_o and pc_valid_o are low.
- R2: sp_o shows the exception pointer when exc_mode_i=1 and the normal pointer when exc_mode_i=0. osp_o always shows the pointer that is not active.
- R3: Push (op 1) requests a write at SP when reg_odd_i=0, or at SP+4 when reg_odd_i=1. The active SP then rises by 8.
- R4: Pop (op 2) requests a read at SP-8 when reg_odd_i=0, or at SP-4 when reg_odd_i=1. The active SP then falls by 8.
- R5: Normal-stack push (op 3) and pop (op 4) use the addressing of R3 and R4 on the normal pointer only, whatever the mode. The exception pointer is left unchanged.
- R6: Write-other (op 8) loads wdata_i into the inactive pointer. Write-active (op 7) loads wdata_i into the active pointer. Neither one makes a memory request.
- R7: Call (op 5) requests a write at SP and raises SP by 8. It loads wdata_i as the return PC into the return register and sets the tag.
- R8: Return (op 6) with the tag set drives pc_valid_o=1 and pc_o to the stored PC in that cycle, with no memory request and no stall. SP falls by 8 and the tag clears.
- R9: Return with the tag clear requests a read at SP-8 and lowers SP by 8. stall_o stays high from that cycle until rd_valid_i is high. In that cycle pc_valid_o=1 and pc_o=rd_data_i. Operations presented while the read is pending are ignored. rd_valid_i has no effect when no read is pending.
- R10: Write-active and a change of exc_mode_i clear the tag, so the next return misses. Write-other leaves the tag untouched. A second call replaces the stored PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation: 0 none, 1 push, 2 pop, 3 normal push, 4 normal pop, 5 call, 6 return, 7 write active, 8 write other |
| reg_odd_i | input | 1 | Register parity for push/pop: 1 selects the upper word of the frame |
| exc_mode_i | input | 1 | Exception mode; selects the active pointer |
| wdata_i | input | 32 | Pointer value for writes, return PC for calls |
| rd_valid_i | input | 1 | Read data valid for a pending return read |
| rd_data_i | input | 32 | Stacked PC returned by memory |
| sp_o | output | 32 | Active stack pointer |
| osp_o | output | 32 | Inactive stack pointer |
| mem_req_o | output | 1 | Memory request this cycle |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | 32 | Byte address of the request |
| pc_valid_o | output | 1 | Return target valid on pc_o |
| pc_o | output | 32 | Return target |
| stall_o | output | 1 | Return waiting for memory |

## Verification
The bench aims at cross-mode cases. A normal-stack push from exception mode that used the active pointer would show the wrong address and corrupt the exception pointer. A write-other that landed on the active pointer would show the new value on sp_o instead of osp_o. For the return shortcut, the bench checks that a stale tag after a mode change or an active-pointer write produces a memory read rather than a stale PC. It also checks that a nested call overwrites the entry and that the second return misses. Finally, it checks that an operation issued during a pending read does not move the pointer, and that an unsolicited rd_valid_i does not raise pc_valid_o.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_PUSH   = 4'd1,
    OP_POP    = 4'd2,
    OP_PUSHN  = 4'd3,
    OP_POPN   = 4'd4,
    OP_CALL   = 4'd5,
    OP_RET    = 4'd6,
    OP_WR_SP  = 4'd7,
    OP_WR_OSP = 4'd8
  } stk_op_e;
endpackage

// File: rtl/stk_bank.sv
module stk_bank #(
  parameter int AW = 32,
  parameter logic [AW-1:0] RST_NRM = 'h1000,
  parameter logic [AW-1:0] RST_EXC = 'h8000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_idx_i,
  input  logic [AW-1:0]       wr_val_i,
  output logic [1:0][AW-1:0]  ptr_o
);
  localparam int NPTR = 2;
  localparam logic [NPTR-1:0][AW-1:0] RST_VAL = {RST_EXC, RST_NRM};

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ptr_o[g] <= RST_VAL[g];
      else if (wr_en_i && (wr_idx_i == 1'(g)))      ptr_o[g] <= wr_val_i;
    end
  end
endmodule

// File: rtl/stk_agu.sv
module stk_agu import stk_pkg::*; #(
  parameter int AW = 32,
  parameter int FRAME_BYTES = 8
) (
  input  stk_op_e        op_i,
  input  logic           odd_i,
  input  logic [AW-1:0]  base_i,
  input  logic [AW-1:0]  wdata_i,
  output logic           req_o,
  output logic           we_o,
  output logic [AW-1:0]  addr_o,
  output logic           upd_o,
  output logic [AW-1:0]  nxt_o
);
  localparam logic [AW-1:0] FRAME = AW'(FRAME_BYTES);
  localparam logic [AW-1:0] HALF  = AW'(FRAME_BYTES / 2);

  logic [AW-1:0] up_off;
  assign up_off = odd_i ? HALF : '0;

  always_comb begin
    req_o  = 1'b0;
    we_o   = 1'b0;
    addr_o = '0;
    upd_o  = 1'b0;
    nxt_o  = base_i;
    unique case (op_i)
      OP_PUSH, OP_PUSHN: begin
        req_o = 1'b1; we_o = 1'b1; addr_o = base_i + up_off;
        upd_o = 1'b1; nxt_o = base_i + FRAME;
      end
      OP_POP, OP_POPN: begin
        req_o = 1'b1; addr_o = base_i - FRAME + up_off;
        upd_o = 1'b1; nxt_o = base_i - FRAME;
      end
      OP_CALL: begin
        req_o = 1'b1; we_o = 1'b1; addr_o = base_i;
        upd_o = 1'b1; nxt_o = base_i + FRAME;
      end
      OP_RET: begin
        req_o = 1'b1; addr_o = base_i - FRAME;
        upd_o = 1'b1; nxt_o = base_i - FRAME;
      end
      OP_WR_SP, OP_WR_OSP: begin
        upd_o = 1'b1; nxt_o = wdata_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_ret.sv
module stk_ret #(
  parameter int AW = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           call_i,
  input  logic           ret_i,
  input  logic           clr_i,
  input  logic [AW-1:0]  ret_pc_i,
  input  logic           rd_valid_i,
  input  logic [AW-1:0]  rd_data_i,
  output logic           hit_o,
  output logic           vld_o,
  output logic           pend_o,
  output logic           pc_valid_o,
  output logic [AW-1:0]  pc_o,
  output logic           stall_o
);
  logic          vld_q, pend_q, miss;
  logic [AW-1:0] ras_q;

  assign hit_o      = ret_i & vld_q;
  assign miss       = ret_i & ~vld_q;
  assign stall_o    = miss | (pend_q & ~rd_valid_i);
  assign pc_valid_o = hit_o | (pend_q & rd_valid_i);
  assign pc_o       = hit_o ? ras_q : rd_data_i;
  assign vld_o      = vld_q;
  assign pend_o     = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      pend_q <= 1'b0;
      ras_q  <= '0;
    end else begin
      if (call_i) begin
        vld_q <= 1'b1;
        ras_q <= ret_pc_i;
      end else if (ret_i || clr_i) begin
        vld_q <= 1'b0;
      end
      if (miss)            pend_q <= 1'b1;
      else if (rd_valid_i) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_sp_ctrl.sv
module dual_sp_ctrl import stk_pkg::*; #(
  parameter int AW = 32,
  parameter logic [AW-1:0] SP_NRM_RST = 'h1000,
  parameter logic [AW-1:0] SP_EXC_RST = 'h8000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [3:0]     op_i,
  input  logic           reg_odd_i,
  input  logic           exc_mode_i,
  input  logic [AW-1:0]  wdata_i,
  input  logic           rd_valid_i,
  input  logic [AW-1:0]  rd_data_i,
  output logic [AW-1:0]  sp_o,
  output logic [AW-1:0]  osp_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic           pc_valid_o,
  output logic [AW-1:0]  pc_o,
  output logic           stall_o
);
  stk_op_e            op;
  logic               acc, pend_q, ras_vld, hit, mode_q;
  logic               tgt, agu_req, agu_upd;
  logic [AW-1:0]      base, nxt;
  logic [1:0][AW-1:0] ptr;

  assign op  = stk_op_e'(op_i);
  assign acc = ~pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= exc_mode_i;
  end

  // pointer index: 0 normal, 1 exception
  always_comb begin
    unique case (op)
      OP_PUSHN, OP_POPN: tgt = 1'b0;
      OP_WR_OSP:         tgt = ~exc_mode_i;
      default:           tgt = exc_mode_i;
    endcase
  end
  assign base = ptr[tgt];

  stk_bank #(.AW(AW), .RST_NRM(SP_NRM_RST), .RST_EXC(SP_EXC_RST)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i (acc & agu_upd),
    .wr_idx_i(tgt),
    .wr_val_i(nxt),
    .ptr_o   (ptr)
  );

  stk_agu #(.AW(AW)) u_agu (
    .op_i   (op),
    .odd_i  (reg_odd_i),
    .base_i (base),
    .wdata_i(wdata_i),
    .req_o  (agu_req),
    .we_o   (mem_we_o),
    .addr_o (mem_addr_o),
    .upd_o  (agu_upd),
    .nxt_o  (nxt)
  );

  stk_ret #(.AW(AW)) u_ret (
    .clk_i, .rst_ni,
    .call_i    (acc && op == OP_CALL),
    .ret_i     (acc && op == OP_RET),
    .clr_i     ((acc && op == OP_WR_SP) || (exc_mode_i != mode_q)),
    .ret_pc_i  (wdata_i),
    .rd_valid_i(rd_valid_i),
    .rd_data_i (rd_data_i),
    .hit_o     (hit),
    .vld_o     (ras_vld),
    .pend_o    (pend_q),
    .pc_valid_o(pc_valid_o),
    .pc_o      (pc_o),
    .stall_o   (stall_o)
  );

  assign mem_req_o = acc & agu_req & ~hit;
  assign sp_o      = ptr[exc_mode_i];
  assign osp_o     = ptr[~exc_mode_i];
endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
  parameter int AW = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [3:0]     op_i,
  input logic           reg_odd_i,
  input logic           exc_mode_i,
  input logic           rd_valid_i,
  input logic [AW-1:0]  sp_o,
  input logic [AW-1:0]  osp_o,
  input logic           mem_req_o,
  input logic           mem_we_o,
  input logic [AW-1:0]  mem_addr_o,
  input logic           pc_valid_o,
  input logic           stall_o,
  input logic           ras_vld,
  input logic           pend_q
);
  assert_push_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd1 && !pend_q) |=>
      ((exc_mode_i != $past(exc_mode_i)) || (sp_o == $past(sp_o) + AW'(8))));

  assert_pop_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd2 && !pend_q && !reg_odd_i) |->
      (mem_req_o && !mem_we_o && mem_addr_o == sp_o - AW'(8)));

  assert_pushn_nrm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd3 && !pend_q && exc_mode_i) |->
      (mem_req_o && mem_addr_o == osp_o + (reg_odd_i ? AW'(4) : AW'(0))));

  assert_call_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd5 && !pend_q) |=> ras_vld);

  assert_ret_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd6 && !pend_q && ras_vld) |-> (pc_valid_o && !stall_o && !mem_req_o));

  assert_ret_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd6 && !pend_q) |=> !ras_vld);

  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !rd_valid_i) |-> (stall_o && !pc_valid_o && !mem_req_o));
endmodule

bind dual_sp_ctrl stk_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_i      (op_i),
  .reg_odd_i (reg_odd_i),
  .exc_mode_i(exc_mode_i),
  .rd_valid_i(rd_valid_i),
  .sp_o      (sp_o),
  .osp_o     (osp_o),
  .mem_req_o (mem_req_o),
  .mem_we_o  (mem_we_o),
  .mem_addr_o(mem_addr_o),
  .pc_valid_o(pc_valid_o),
  .stall_o   (stall_o),
  .ras_vld   (ras_vld),
  .pend_q    (pend_q)
);

// File: tb/dual_sp_ctrl_tb.sv
`timescale 1ns/1ps
module dual_sp_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic        odd = 1'b0, mode = 1'b0, rdv = 1'b0;
  logic [31:0] wdata = '0, rdd = '0;
  logic [31:0] sp, osp, addr, pc;
  logic        req, we, pcv, stall;
  int          nchk = 0, nfail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dual_sp_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .reg_odd_i(odd), .exc_mode_i(mode),
    .wdata_i(wdata), .rd_valid_i(rdv), .rd_data_i(rdd),
    .sp_o(sp), .osp_o(osp), .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr),
    .pc_valid_o(pcv), .pc_o(pc), .stall_o(stall)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic        odd;
    logic        mode;
    logic [31:0] data;
    logic        req;
    logic        we;
    logic [31:0] addr;
    logic [31:0] sp;
    logic [31:0] osp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 1'b0, 1'b0, 32'h0,    1'b1, 1'b1, 32'h1000, 32'h1000, 32'h8000}, // R3 even
    '{4'd1, 1'b1, 1'b0, 32'h0,    1'b1, 1'b1, 32'h100C, 32'h1008, 32'h8000}, // R3 odd
    '{4'd2, 1'b1, 1'b0, 32'h0,    1'b1, 1'b0, 32'h100C, 32'h1010, 32'h8000}, // R4 odd
    '{4'd2, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 32'h1000, 32'h1008, 32'h8000}, // R4 even
    '{4'd0, 1'b0, 1'b1, 32'h0,    1'b0, 1'b0, 32'h0,    32'h8000, 32'h1000}, // R2
    '{4'd1, 1'b0, 1'b1, 32'h0,    1'b1, 1'b1, 32'h8000, 32'h8000, 32'h1000}, // R3 exc
    '{4'd3, 1'b1, 1'b1, 32'h0,    1'b1, 1'b1, 32'h1004, 32'h8008, 32'h1000}, // R5 pushn
    '{4'd4, 1'b0, 1'b1, 32'h0,    1'b1, 1'b0, 32'h1000, 32'h8008, 32'h1008}, // R5 popn
    '{4'd8, 1'b0, 1'b1, 32'h2000, 1'b0, 1'b0, 32'h0,    32'h8008, 32'h1000}, // R6 wr other
    '{4'd0, 1'b0, 1'b1, 32'h0,    1'b0, 1'b0, 32'h0,    32'h8008, 32'h2000}, // R6 seen
    '{4'd7, 1'b0, 1'b0, 32'h3000, 1'b0, 1'b0, 32'h0,    32'h2000, 32'h8008}, // R6 wr active
    '{4'd0, 1'b0, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0,    32'h3000, 32'h8008}  // R6 seen
  };

  task automatic chk(input string req_tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] o, input logic od, input logic m,
                      input logic [31:0] d, input logic rv, input logic [31:0] rd);
    @(negedge clk);
    op = o; odd = od; mode = m; wdata = d; rdv = rv; rdd = rd;
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "sp reset", sp, 32'h1000);
    chk("R1", "osp reset", osp, 32'h8000);
    chk("R1", "stall reset", {31'b0, stall}, 0);
    chk("R1", "pcv reset", {31'b0, pcv}, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].op, VECS[i].odd, VECS[i].mode, VECS[i].data, 1'b0, 32'h0);
      chk("R2", $sformatf("v%0d sp", i), sp, VECS[i].sp);
      chk("R2", $sformatf("v%0d osp", i), osp, VECS[i].osp);
      chk("R3", $sformatf("v%0d req", i), {31'b0, req}, {31'b0, VECS[i].req});
      if (VECS[i].req) begin
        chk("R4", $sformatf("v%0d we", i), {31'b0, we}, {31'b0, VECS[i].we});
        chk("R5", $sformatf("v%0d addr", i), addr, VECS[i].addr);
      end
    end

    // call then hit
    step(4'd5, 0, 0, 32'hABCD, 0, 0);
    chk("R7", "call req", {30'b0, req, we}, 3);
    chk("R7", "call addr", addr, 32'h3000);
    step(4'd6, 0, 0, 0, 0, 0);
    chk("R7", "sp after call", sp, 32'h3008);
    chk("R8", "hit pcv", {31'b0, pcv}, 1);
    chk("R8", "hit pc", pc, 32'hABCD);
    chk("R8", "hit no req/stall", {30'b0, req, stall}, 0);
    // tag cleared: miss
    step(4'd6, 0, 0, 0, 0, 0);
    chk("R8", "sp after hit", sp, 32'h3000);
    chk("R9", "miss req/we", {30'b0, req, we}, 2);
    chk("R9", "miss addr", addr, 32'h2FF8);
    chk("R9", "miss stall", {30'b0, stall, pcv}, 2);
    step(4'd1, 0, 0, 0, 0, 0);
    chk("R9", "pend stall", {31'b0, stall}, 1);
    chk("R9", "pend push no req", {31'b0, req}, 0);
    chk("R9", "sp after miss", sp, 32'h2FF8);
    step(4'd0, 0, 0, 0, 1, 32'h5555);
    chk("R9", "fill stall", {31'b0, stall}, 0);
    chk("R9", "fill pcv", {31'b0, pcv}, 1);
    chk("R9", "fill pc", pc, 32'h5555);
    chk("R9", "push ignored sp", sp, 32'h2FF8);
    step(4'd0, 0, 0, 0, 1, 32'h1);
    chk("R9", "stray rd_valid pcv", {31'b0, pcv}, 0);

    // mode change clears tag
    step(4'd5, 0, 0, 32'h1111, 0, 0);
    step(4'd0, 0, 1, 0, 0, 0);
    step(4'd6, 0, 0, 0, 0, 0);
    chk("R10", "mode clr miss req", {31'b0, req}, 1);
    chk("R10", "mode clr miss addr", addr, 32'h2FF8);
    chk("R10", "mode clr stall", {31'b0, stall}, 1);
    step(4'd0, 0, 0, 0, 1, 32'h77);
    chk("R10", "mode clr fill", pc, 32'h77);

    // write-active clears tag
    step(4'd5, 0, 0, 32'h2222, 0, 0);
    step(4'd7, 0, 0, 32'h4000, 0, 0);
    step(4'd6, 0, 0, 0, 0, 0);
    chk("R10", "wr_sp miss req", {31'b0, req}, 1);
    chk("R10", "wr_sp miss addr", addr, 32'h3FF8);
    step(4'd0, 0, 0, 0, 1, 32'h88);
    chk("R10", "wr_sp fill pcv", {31'b0, pcv}, 1);

    // write-other keeps tag
    step(4'd5, 0, 0, 32'h3333, 0, 0);
    step(4'd8, 0, 0, 32'h9000, 0, 0);
    step(4'd6, 0, 0, 0, 0, 0);
    chk("R10", "wr_osp hit pcv", {30'b0, pcv, req}, 2);
    chk("R10", "wr_osp hit pc", pc, 32'h3333);
    chk("R6", "osp written", osp, 32'h9000);

    // nested calls
    step(4'd5, 0, 0, 32'h4444, 0, 0);
    step(4'd5, 0, 0, 32'h5555, 0, 0);
    step(4'd6, 0, 0, 0, 0, 0);
    chk("R10", "nested hit pc", pc, 32'h5555);
    step(4'd6, 0, 0, 0, 0, 0);
    chk("R10", "nested 2nd miss", {30'b0, req, stall}, 3);
    chk("R10", "nested 2nd addr", addr, 32'h3FF8);
    step(4'd0, 0, 0, 0, 1, 32'h4444);
    chk("R9", "nested fill pc", pc, 32'h4444);
    step(4'd0, 0, 0, 0, 0, 0);
    chk("R4", "final sp", sp, 32'h3FF8);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule